// File: doc/BRIEF.md
# Timebase Counter with Input Capture

This block is a hidden 8-bit timebase counter with one input-capture channel. A divide-by-32 enable is derived from the system (oscillator) clock, and the counter advances once per enable pulse. It runs from 0 up to a terminal count of F9h and then returns to 0. That is a 250-step cycle, or 1 ms at an 8 MHz clock. A control bit can stretch the overflow period to two full cycles. Each overflow event sets a timebase flag. Software clears that flag by reading the register that holds it. A second interrupt line can be enabled for the flag.

An external capture pin passes through a two-flop synchronizer. The edge that triggers a capture, rising or falling, is selected by a control bit. On that edge the current counter value is copied into a read-only capture register and a capture flag is raised. While the flag is pending, the block takes no further captures. Reading the capture register clears the flag. When a clearing read and a new set event fall in the same cycle, the set event wins, so no event is lost.

Two state machines carry the sequencing. The overflow phase machine has the states `PH_FIRST` and `PH_SECOND`:

- `PH_FIRST` → `PH_FIRST`: a wrap with doubling off. It raises an overflow event.
- `PH_FIRST` → `PH_SECOND`: a wrap with doubling on. It raises no event.
- `PH_SECOND` → `PH_FIRST`: the next wrap. It raises the event.

The capture machine has the states `CAP_ARMED` and `CAP_HELD`:

- `CAP_ARMED` → `CAP_HELD`: the selected edge arrives, and the value is loaded.
- `CAP_HELD` → `CAP_ARMED`: a clearing read with no edge in the same cycle.
- `CAP_HELD` → `CAP_HELD`: a clearing read in the same cycle as an edge. The new value is loaded.

Top module: `ltb_capture_timer`

## Requirements
- R1: After reset, the counter is 0, both flags are 0, the capture register is 0, all control bits are 0, and both interrupt outputs are low.
- R2: The counter advances by one on every 32nd clock cycle. The first step falls on the 32nd rising edge after reset is released.
- R3: After F9h the counter goes back to 00h. With doubling off, the timebase flag (bit 7 of the register at address 0) rises exactly 8000 clock edges after reset release, and again every 8000 edges after that.
- R4: With the double bit (address 0, bit 1) set, the flag rises only on every second wrap. From reset it first rises 16000 edges after release.
- R5: `irq_tb` is high exactly while the timebase flag and the timebase enable (address 0, bit 0) are both set.
- R6: A read strobe at address 0 clears the timebase flag on the following edge. The read returns the flag as it was before the clear.
- R7: A selected edge on `cap_pin` copies the counter into the capture register (address 2). The copied value is the counter as it stands after the second edge that follows the pin change. The capture flag (address 1, bit 7) rises after the third edge. `irq_cap` follows the flag AND the capture enable (address 1, bit 0).
- R8: While the capture flag is set, further edges on `cap_pin` leave the capture register unchanged.
- R9: With address 1, bit 1 at 0 the rising edge captures. With it at 1 the falling edge captures. The other edge is ignored in both cases.
- R10: A read strobe at address 2 clears the capture flag and re-arms capture.
- R11: When a clearing read and a set event for the same flag fall in one cycle, the flag stays set. For a capture, the new value is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address (0 timebase ctl/status, 1 capture ctl/status, 2 capture value) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (causes flag clears) |
| rdata | output | 8 | Read data, combinational from addr |
| cap_pin | input | 1 | Asynchronous capture input |
| irq_tb | output | 1 | Timebase interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
The bench times the first overflow flag to the exact edge, both with and without doubling. A counter that wrapped at FFh, or that raised an event on every wrap in doubled mode, would land thousands of cycles off. Captures are taken at chosen cycles, including one just after reset and one after a wrap, and the stored value is compared with a count the bench derives from elapsed edges. A wrong synchronizer depth or prescale phase would therefore show up as an off-by-one value. Further cases cover a second edge while the capture flag is pending, an edge of the unselected polarity, and a clearing read that lands in the same cycle as a new overflow or capture. A design that let the clear win would lose that event and report a cleared flag.

// File: rtl/ltb_pkg.sv
package ltb_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_TB   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CAPC = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CAPV = 2'd2;

    typedef enum logic {PH_FIRST, PH_SECOND} phase_t;
    typedef enum logic {CAP_ARMED, CAP_HELD} cap_state_t;
endpackage

// File: rtl/ltb_prescaler.sv
module ltb_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    // R2: enable pulses are isolated single cycles
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ltb_timebase.sv
module ltb_timebase
    import ltb_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TERM  = 249
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dbl,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

    logic [CNT_W-1:0] cnt_q;
    phase_t           ph_q, ph_d;
    logic             wrap;

    assign wrap = tick && (cnt_q == TERM_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph_q <= PH_FIRST;
        else
            ph_q <= ph_d;
    end

    // next state and event output
    always_comb begin
        ph_d    = ph_q;
        ovf_evt = 1'b0;
        if (wrap) begin
            unique case (ph_q)
                PH_FIRST: begin
                    if (dbl) ph_d = PH_SECOND;
                    else     ovf_evt = 1'b1;
                end
                PH_SECOND: begin
                    ovf_evt = 1'b1;
                    ph_d    = PH_FIRST;
                end
                default: ph_d = PH_FIRST;
            endcase
        end
    end

    assign cnt = cnt_q;

    // R3: counter never exceeds the terminal count
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM_V);
    // R3: a step at the terminal count lands on zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == TERM_V) |=> cnt_q == '0);
    // R4: in doubled mode the first wrap raises no event
    a_r4_dbl_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && dbl && ph_q == PH_FIRST) |-> !ovf_evt);
endmodule

// File: rtl/ltb_capture.sv
module ltb_capture
    import ltb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             fall_sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic             clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag
);
    logic       sync1_q, sync2_q, prev_q;
    logic       hit;
    logic       load;
    cap_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign hit = fall_sel ? (prev_q && !sync2_q) : (!prev_q && sync2_q);

    // capture state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= CAP_ARMED;
        else
            st_q <= st_d;
    end

    // next state and load decision
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            CAP_ARMED: begin
                if (hit) begin
                    st_d = CAP_HELD;
                    load = 1'b1;
                end
            end
            CAP_HELD: begin
                if (clr) begin
                    if (hit) load = 1'b1;
                    else     st_d = CAP_ARMED;
                end
            end
            default: st_d = CAP_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_val <= '0;
        else if (load)
            cap_val <= cnt;
    end

    assign cap_flag = (st_q == CAP_HELD);

    // R8: a pending capture with no clear keeps its value
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAP_HELD && !clr) |=> $stable(cap_val));
    // R10: clear without a new edge re-arms
    a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAP_HELD && clr && !hit) |=> st_q == CAP_ARMED);
    // R11: clear colliding with an edge keeps the flag
    a_r11_cap_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> cap_flag);
endmodule

// File: rtl/ltb_capture_timer.sv
module ltb_capture_timer
    import ltb_pkg::*;
#(
    parameter int PRESC = 32,
    parameter int CNT_W = 8,
    parameter int TERM  = 249
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              cap_pin,
    output logic              irq_tb,
    output logic              irq_cap
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             ovf_evt;
    logic [CNT_W-1:0] cap_val;
    logic             cap_flag;
    logic             tb_ie, tb_dbl, cap_ie, cap_fall;
    logic             tb_flag;
    logic             rd_tb, rd_capv;

    ltb_prescaler #(.DIV(PRESC)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ltb_timebase #(.CNT_W(CNT_W), .TERM(TERM)) u_tbase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .dbl    (tb_dbl),
        .cnt    (cnt),
        .ovf_evt(ovf_evt)
    );

    assign rd_tb   = rd_en && (addr == ADDR_TB);
    assign rd_capv = rd_en && (addr == ADDR_CAPV);

    ltb_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_pin),
        .fall_sel(cap_fall),
        .cnt     (cnt),
        .clr     (rd_capv),
        .cap_val (cap_val),
        .cap_flag(cap_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_ie    <= 1'b0;
            tb_dbl   <= 1'b0;
            cap_ie   <= 1'b0;
            cap_fall <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_TB) begin
                tb_ie  <= wdata[0];
                tb_dbl <= wdata[1];
            end else if (addr == ADDR_CAPC) begin
                cap_ie   <= wdata[0];
                cap_fall <= wdata[1];
            end
        end
    end

    // set has priority over the read-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tb_flag <= 1'b0;
        else if (ovf_evt)
            tb_flag <= 1'b1;
        else if (rd_tb)
            tb_flag <= 1'b0;
    end

    always_comb begin
        unique case (addr)
            ADDR_TB:   rdata = {tb_flag, 5'b0, tb_dbl, tb_ie};
            ADDR_CAPC: rdata = {cap_flag, 5'b0, cap_fall, cap_ie};
            ADDR_CAPV: rdata = {{PAD_W{1'b0}}, cap_val};
            default:   rdata = '0;
        endcase
    end

    assign irq_tb  = tb_flag && tb_ie;
    assign irq_cap = cap_flag && cap_ie;

    // R6: a read with no new event clears the flag
    a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_tb && !ovf_evt) |=> !tb_flag);
    // R11: an overflow event always leaves the flag set
    a_r11_tb_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> tb_flag);
    // R5: a disabled timebase interrupt stays low
    a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_ie |-> !irq_tb);
endmodule

// File: tb/ltb_capture_timer_tb.sv
module ltb_capture_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       cap_pin = 1'b0;
    logic       irq_tb, irq_cap;

    int n_chk = 0;
    int n_bad = 0;
    int ncyc  = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ncyc <= 0;
        else        ncyc <= ncyc + 1;
    end

    ltb_capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .cap_pin(cap_pin),
        .irq_tb(irq_tb), .irq_cap(irq_cap)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cap_pin = 1'b0;
        rd_en = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_to(input int n);
        while (ncyc < n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        peek(2'd0, d); check("R1 tb reg", d, 0);
        peek(2'd1, d); check("R1 cap reg", d, 0);
        peek(2'd2, d); check("R1 cap value", d, 0);
        check("R1 irq_tb", irq_tb, 0);
        check("R1 irq_cap", irq_cap, 0);
    endtask

    task automatic t_base_period();
        logic [7:0] d;
        int t;
        do_reset();
        t = -1;
        for (int i = 0; i < 9000; i++) begin
            peek(2'd0, d);
            if (d[7]) begin t = ncyc; break; end
            @(negedge clk);
        end
        check("R3 first overflow edge", t, 8000);
        check("R5 irq low with enable clear", irq_tb, 0);
        bus_write(2'd0, 8'h01);
        #1 check("R5 irq high with enable set", irq_tb, 1);
        bus_read(2'd0, d);
        check("R6 read returns flag", d[7], 1);
        peek(2'd0, d);
        check("R6 flag cleared by read", d[7], 0);
        check("R6 irq drops", irq_tb, 0);
        wait_to(15999);
        peek(2'd0, d);
        check("R3 no flag before second period", d[7], 0);
        @(negedge clk);
        peek(2'd0, d);
        check("R3 flag at second period", d[7], 1);
        // clearing read in the same cycle as the next event
        wait_to(23999);
        bus_read(2'd0, d);
        peek(2'd0, d);
        check("R11 timebase set beats clear", d[7], 1);
    endtask

    task automatic t_double_period();
        logic [7:0] d;
        int t;
        do_reset();
        bus_write(2'd0, 8'h02);
        t = -1;
        for (int i = 0; i < 17000; i++) begin
            peek(2'd0, d);
            if (d[7]) begin t = ncyc; break; end
            @(negedge clk);
        end
        check("R4 doubled overflow edge", t, 16000);
    endtask

    task automatic pin_at(input int n, input logic v);
        wait_to(n);
        cap_pin = v;
    endtask

    task automatic t_capture_rise();
        logic [7:0] d;
        do_reset();
        bus_write(2'd1, 8'h01);
        pin_at(1, 1'b1);
        wait_to(3);
        peek(2'd1, d); check("R7 flag not yet at edge+2", d[7], 0);
        wait_to(4);
        peek(2'd1, d); check("R7 flag after third edge", d[7], 1);
        peek(2'd2, d); check("R1 counter starts at zero", d, 0);
        check("R7 irq_cap raised", irq_cap, 1);
        pin_at(10, 1'b0);
        pin_at(300, 1'b1);
        wait_to(310);
        peek(2'd2, d); check("R8 second edge ignored", d, 0);
        bus_read(2'd2, d);
        peek(2'd1, d); check("R10 flag cleared by value read", d[7], 0);
        check("R10 irq_cap dropped", irq_cap, 0);
        pin_at(400, 1'b0);
        pin_at(1000, 1'b1);
        wait_to(1003);
        peek(2'd2, d); check("R2 counter value at 1002 edges", d, 31);
        bus_read(2'd2, d);
        pin_at(1100, 1'b0);
        pin_at(8100, 1'b1);
        wait_to(8103);
        peek(2'd2, d); check("R3 value after wrap", d, 3);
    endtask

    task automatic t_capture_fall();
        logic [7:0] d;
        do_reset();
        bus_write(2'd1, 8'h02);
        pin_at(50, 1'b1);
        wait_to(60);
        peek(2'd1, d); check("R9 rising ignored in falling mode", d[7], 0);
        check("R9 irq_cap low when disabled", irq_cap, 0);
        pin_at(500, 1'b0);
        wait_to(503);
        peek(2'd1, d); check("R9 falling edge captures", d[7], 1);
        peek(2'd2, d); check("R9 falling capture value", d, 15);
    endtask

    task automatic t_capture_collide();
        logic [7:0] d;
        do_reset();
        bus_write(2'd1, 8'h00);
        pin_at(100, 1'b1);
        pin_at(200, 1'b0);
        pin_at(640, 1'b1);
        wait_to(642);
        bus_read(2'd2, d);
        check("R11 read sees old value", d, 3);
        peek(2'd1, d); check("R11 capture flag kept", d[7], 1);
        peek(2'd2, d); check("R11 new value loaded", d, 20);
    endtask

    initial begin
        #(150000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_base_period();
        t_double_period();
        t_capture_rise();
        t_capture_fall();
        t_capture_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule